// File: doc/BRIEF.md
# Abstract Command Controller for a Debug Module

This block is the command engine of a processor debug module. The debugger reaches it through a simple word-wide register port. It loads operands into a set of data registers and then writes a command word. The engine then raises a one-cycle request toward the selected hart and holds a busy flag until the hart answers with a done pulse. The result that comes back with the done pulse lands in data register 0.

The block also holds a program buffer of exactly eight instruction words. The debugger can read and write every word, so it can find the buffer size by writing patterns and reading them back. The buffer never runs by itself, and the block never adds a break instruction to it. Only a command that asks for the buffer makes the hart use it, so the debugger has to write the final break word itself.

An autoexec mask can mark individual data registers. Any read or write of a marked register issues the last accepted command again, so a debugger can stream words without writing the command each time. While a command is in flight, writes to the hart-select register are dropped. A sticky error code records accesses that arrived while the engine was busy, and no command launches while that code is nonzero.

Top module: `acmd_engine`

## Requirements
- R1: After reset, busy and hartCmdValid are 0, and the error code, data registers, program buffer, autoexec mask, command and hart select all read 0.
- R2: A command write (address 0x09) while the engine is idle and the error code is 0 sets busy and hartCmdValid in the following cycle. hartCmd then equals the written word, and hartArgs shows the data registers, with data register i in bits [32*i+31:32*i].
- R3: hartCmdValid is high for exactly one cycle per launch, while busy stays high until the hart completes.
- R4: The hart select register (address 0x0B, low 4 bits, driven on hartSel) takes writes only while the engine is idle. Writes while busy leave hartSel unchanged.
- R5: A hartDone pulse while busy clears busy in the next cycle and loads hartResult into data register 0. A hartDone pulse while idle changes nothing.
- R6: While busy, writes to a data register, to the command register or to the program buffer, and accesses to autoexec-marked data registers, have no effect. If the error code is 0, each of them sets it to 1.
- R7: The error code sits in bits [2:0] of the control register (address 0x08) and is cleared only by writing ones to those bits. Writing zeros leaves it unchanged. While it is nonzero, command writes and autoexec accesses do not launch, and the command register keeps its value.
- R8: The program buffer has exactly 8 words at addresses 0x10 to 0x17. Each word reads back exactly what was written, with no inserted instruction, and a program buffer write never launches a command.
- R9: The autoexec mask is at address 0x0A, with bit i for data register i (2 data registers at 0x00 and 0x01). A read or write of a marked data register while idle with no error relaunches the last accepted command. On a write, the new value is already visible in hartArgs.
- R10: Bit 8 of the control register reads as busy. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Debugger register write strobe |
| regRdEn | input | 1 | Debugger register read strobe (counts as an access for autoexec) |
| regAddr | input | 5 | Debugger register word address |
| regWrData | input | 32 | Debugger write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| hartSel | output | 4 | Currently selected hart |
| hartCmdValid | output | 1 | One-cycle command request to the hart |
| hartCmd | output | 32 | Command word presented to the hart |
| hartArgs | output | 64 | Data register contents as operands |
| hartDone | input | 1 | Completion pulse from the hart |
| hartResult | input | 32 | Result returned with hartDone |
| busy | output | 1 | A command is in flight |

## Verification
The hardest state to reach from the ports is one where the engine is busy and, at the same moment, a debugger access collides with the in-flight command. Examples are a data write, a hart-select write or an autoexec read arriving before the hart answers. The bench gets there by launching a command and then holding hartDone low while it issues these accesses. It then reads back the data registers, hartSel and the sticky error before it releases the done pulse. After that it reaches the error-pending idle state and checks that zero-writes do not clear the code and that command writes stay dormant.

// File: rtl/acmd_pkg.sv
package acmd_pkg;
  localparam int ADDR_W   = 5;
  localparam int PB_WORDS = 8;
  localparam int ERR_W    = 3;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h08;
  localparam logic [ADDR_W-1:0] CMD_ADDR  = 5'h09;
  localparam logic [ADDR_W-1:0] AUTO_ADDR = 5'h0A;
  localparam logic [ADDR_W-1:0] HSEL_ADDR = 5'h0B;
  localparam logic [ADDR_W-1:0] PB_BASE   = 5'h10;

  localparam logic [ERR_W-1:0] ERR_NONE = 3'd0;
  localparam logic [ERR_W-1:0] ERR_BUSY = 3'd1;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic dataWr;
    logic pbWr;
    logic cmdWr;
    logic maskWr;
    logic hselWr;
    logic resultWr;
  } acmd_strobe_t;
endpackage

// File: rtl/acmd_ctrl.sv
module acmd_ctrl import acmd_pkg::*; #(
  parameter int NUM_DATA = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [ERR_W-1:0]      clrBits,
  input  logic                  autoHit,
  input  logic                  hartDone,
  output acmd_strobe_t          strobe,
  output logic                  busy,
  output logic                  hartCmdValid,
  output logic [ERR_W-1:0]      errCode
);
  logic isData, isPb, isCmd, autoAcc, guardedWr, busyViol, launch, errClr;

  always_comb begin
    isData    = int'(regAddr) < NUM_DATA;
    isPb      = (regAddr >= PB_BASE) && (int'(regAddr) < int'(PB_BASE) + PB_WORDS);
    isCmd     = regAddr == CMD_ADDR;
    autoAcc   = (regWrEn || regRdEn) && isData && autoHit;
    guardedWr = regWrEn && (isData || isPb || isCmd);
    busyViol  = busy && (guardedWr || autoAcc);
    launch    = !busy && (errCode == ERR_NONE) && ((regWrEn && isCmd) || autoAcc);
    errClr    = regWrEn && (regAddr == CTRL_ADDR);

    strobe.dataWr   = regWrEn && isData && !busy;
    strobe.pbWr     = regWrEn && isPb && !busy;
    strobe.cmdWr    = regWrEn && isCmd && launch;
    strobe.maskWr   = regWrEn && (regAddr == AUTO_ADDR);
    strobe.hselWr   = regWrEn && (regAddr == HSEL_ADDR) && !busy;
    strobe.resultWr = hartDone && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= 1'b0;
      hartCmdValid <= 1'b0;
      errCode      <= ERR_NONE;
    end else begin
      hartCmdValid <= launch;
      if (launch)               busy <= 1'b1;
      else if (strobe.resultWr) busy <= 1'b0;
      if (errClr)                                   errCode <= errCode & ~clrBits;
      else if (busyViol && (errCode == ERR_NONE))   errCode <= ERR_BUSY;
    end
  end
endmodule

// File: rtl/acmd_datapath.sv
module acmd_datapath import acmd_pkg::*; #(
  parameter int XLEN     = 32,
  parameter int NUM_DATA = 2,
  parameter int HART_W   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  acmd_strobe_t             strobe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [XLEN-1:0]          regWrData,
  input  logic [XLEN-1:0]          hartResult,
  input  logic                     busy,
  input  logic [ERR_W-1:0]         errCode,
  output logic [XLEN-1:0]          regRdData,
  output logic [XLEN-1:0]          cmdWord,
  output logic [NUM_DATA*XLEN-1:0] hartArgs,
  output logic [HART_W-1:0]        hartSel,
  output logic                     autoHit
);
  logic [XLEN-1:0]     dataQ [NUM_DATA];
  logic [XLEN-1:0]     pbQ   [PB_WORDS];
  logic [NUM_DATA-1:0] autoMask;

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rstN)                                               dataQ[i] <= '0;
      else if (strobe.resultWr && i == 0)                      dataQ[i] <= hartResult;
      else if (strobe.dataWr && regAddr == ADDR_W'(i))         dataQ[i] <= regWrData;
    end
    assign hartArgs[i*XLEN +: XLEN] = dataQ[i];
  end

  for (genvar j = 0; j < PB_WORDS; j++) begin : g_pb
    always_ff @(posedge clk) begin
      if (!rstN)                                               pbQ[j] <= '0;
      else if (strobe.pbWr && regAddr == PB_BASE + ADDR_W'(j)) pbQ[j] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord  <= '0;
      autoMask <= '0;
      hartSel  <= '0;
    end else begin
      if (strobe.cmdWr)  cmdWord  <= regWrData;
      if (strobe.maskWr) autoMask <= regWrData[NUM_DATA-1:0];
      if (strobe.hselWr) hartSel  <= regWrData[HART_W-1:0];
    end
  end

  always_comb begin
    autoHit   = 1'b0;
    regRdData = '0;
    for (int i = 0; i < NUM_DATA; i++) begin
      if (regAddr == ADDR_W'(i)) begin
        autoHit   = autoMask[i];
        regRdData = dataQ[i];
      end
    end
    for (int j = 0; j < PB_WORDS; j++)
      if (regAddr == PB_BASE + ADDR_W'(j)) regRdData = pbQ[j];
    case (regAddr)
      CTRL_ADDR: begin
        regRdData[ERR_W-1:0] = errCode;
        regRdData[8]         = busy;
      end
      CMD_ADDR:  regRdData = cmdWord;
      AUTO_ADDR: regRdData[NUM_DATA-1:0] = autoMask;
      HSEL_ADDR: regRdData[HART_W-1:0] = hartSel;
      default: ;
    endcase
  end
endmodule

// File: rtl/acmd_engine.sv
module acmd_engine import acmd_pkg::*; #(
  parameter int XLEN     = 32,
  parameter int NUM_DATA = 2,
  parameter int HART_W   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [XLEN-1:0]          regWrData,
  output logic [XLEN-1:0]          regRdData,
  output logic [HART_W-1:0]        hartSel,
  output logic                     hartCmdValid,
  output logic [XLEN-1:0]          hartCmd,
  output logic [NUM_DATA*XLEN-1:0] hartArgs,
  input  logic                     hartDone,
  input  logic [XLEN-1:0]          hartResult,
  output logic                     busy
);
  acmd_strobe_t     strobe;
  logic [ERR_W-1:0] errCode;
  logic             autoHit;

  acmd_ctrl #(.NUM_DATA(NUM_DATA)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .clrBits(regWrData[ERR_W-1:0]), .autoHit(autoHit),
    .hartDone(hartDone), .strobe(strobe), .busy(busy),
    .hartCmdValid(hartCmdValid), .errCode(errCode)
  );

  acmd_datapath #(.XLEN(XLEN), .NUM_DATA(NUM_DATA), .HART_W(HART_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .hartResult(hartResult), .busy(busy),
    .errCode(errCode), .regRdData(regRdData), .cmdWord(hartCmd),
    .hartArgs(hartArgs), .hartSel(hartSel), .autoHit(autoHit)
  );
endmodule

// File: rtl/acmd_checker.sv
module acmd_checker import acmd_pkg::*; #(
  parameter int XLEN   = 32,
  parameter int HART_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [HART_W-1:0] hartSel,
  input logic              hartCmdValid,
  input logic              hartDone,
  input logic [XLEN-1:0]   hartResult,
  input logic [XLEN-1:0]   hartArg0,
  input logic              busy,
  input logic [ERR_W-1:0]  errCode
);
  a_r2_valid_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> hartCmdValid);

  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hartCmdValid |=> !hartCmdValid);

  a_r4_hartsel_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == HSEL_ADDR) |=> $stable(hartSel));

  a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hartDone) |=> !busy);

  a_r5_result_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hartDone) |=> hartArg0 == $past(hartResult));

  a_r6_busy_error: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == CMD_ADDR && errCode == ERR_NONE) |=> errCode == ERR_BUSY);

  a_r7_error_blocks_launch: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_NONE && !busy) |=> !hartCmdValid);
endmodule

bind acmd_engine acmd_checker #(.XLEN(XLEN), .HART_W(HART_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .hartSel(hartSel), .hartCmdValid(hartCmdValid), .hartDone(hartDone),
  .hartResult(hartResult), .hartArg0(hartArgs[XLEN-1:0]), .busy(busy),
  .errCode(errCode)
);

// File: tb/test_acmd_engine.sv
`timescale 1ns/1ps
module test_acmd_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  hartSel;
  logic        hartCmdValid;
  logic [31:0] hartCmd;
  logic [63:0] hartArgs;
  logic        hartDone = 1'b0;
  logic [31:0] hartResult = '0;
  logic        busy;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  acmd_engine i_acmd_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .hartSel(hartSel), .hartCmdValid(hartCmdValid), .hartCmd(hartCmd),
    .hartArgs(hartArgs), .hartDone(hartDone), .hartResult(hartResult),
    .busy(busy)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{5'h00, 32'h1111_1111, 32'h1111_1111},
    '{5'h01, 32'h2222_2222, 32'h2222_2222},
    '{5'h10, 32'hA000_0001, 32'hA000_0001},
    '{5'h11, 32'hB000_0002, 32'hB000_0002},
    '{5'h12, 32'hC000_0003, 32'hC000_0003},
    '{5'h13, 32'hD000_0004, 32'hD000_0004},
    '{5'h14, 32'hE000_0005, 32'hE000_0005},
    '{5'h15, 32'hF000_0006, 32'hF000_0006},
    '{5'h16, 32'h0000_0073, 32'h0000_0073},
    '{5'h17, 32'h0010_0073, 32'h0010_0073},
    '{5'h1F, 32'hFFFF_FFFF, 32'h0000_0000},
    '{5'h0B, 32'hFFFF_FFFF, 32'h0000_000F},
    '{5'h0A, 32'hFFFF_FFFF, 32'h0000_0003}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic done(input logic [31:0] r);
    @(negedge clk);
    hartDone = 1'b1; hartResult = r;
    @(negedge clk);
    hartDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 valid", {31'b0, hartCmdValid}, 32'h0);
    chk("R1 hartSel", {28'b0, hartSel}, 32'h0);
    rd(5'h08, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h00, v); chk("R1 data0", v, 32'h0);
    rd(5'h09, v); chk("R1 cmd", v, 32'h0);
    rd(5'h17, v); chk("R1 pb7", v, 32'h0);

    // R8 R10 R4 R9 write/readback table
    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].wdata);
      chk("R8 no launch from table write", {31'b0, busy}, 32'h0);
      rd(VECS[i].addr, v);
      chk("R10 table readback", v, VECS[i].exp);
    end
    wr(5'h0A, 32'h0);

    // R4 hart select while idle
    wr(5'h0B, 32'h5); chk("R4 hartSel idle", {28'b0, hartSel}, 32'h5);

    // R2 launch
    wr(5'h00, 32'hAAAA_0000);
    wr(5'h01, 32'hBBBB_0001);
    wr(5'h09, 32'h00C0_FFEE);
    chk("R2 busy", {31'b0, busy}, 32'h1);
    chk("R2 valid", {31'b0, hartCmdValid}, 32'h1);
    chk("R2 hartCmd", hartCmd, 32'h00C0_FFEE);
    chk("R2 arg0", hartArgs[31:0], 32'hAAAA_0000);
    chk("R2 arg1", hartArgs[63:32], 32'hBBBB_0001);
    // R3 pulse width
    rd(5'h08, v);
    chk("R10 ctrl busy bit", v, 32'h100);
    chk("R3 valid dropped", {31'b0, hartCmdValid}, 32'h0);
    chk("R3 busy held", {31'b0, busy}, 32'h1);

    // R4 locked while busy
    wr(5'h0B, 32'h9); chk("R4 hartSel locked", {28'b0, hartSel}, 32'h5);
    // R6 writes while busy
    wr(5'h00, 32'hDEAD_BEEF);
    rd(5'h00, v); chk("R6 data0 unchanged", v, 32'hAAAA_0000);
    wr(5'h12, 32'h1234_5678);
    rd(5'h12, v); chk("R6 pb unchanged", v, 32'hC000_0003);
    rd(5'h08, v); chk("R6 err set", v, 32'h101);

    // R5 completion
    done(32'h5555_AAAA);
    chk("R5 busy cleared", {31'b0, busy}, 32'h0);
    chk("R5 result in data0", hartArgs[31:0], 32'h5555_AAAA);

    // R7 sticky error blocks launch
    wr(5'h09, 32'h0000_0BAD);
    chk("R7 no launch busy", {31'b0, busy}, 32'h0);
    rd(5'h09, v); chk("R7 cmd kept", v, 32'h00C0_FFEE);
    wr(5'h08, 32'h0);
    rd(5'h08, v); chk("R7 zero write keeps err", v, 32'h1);
    wr(5'h08, 32'h7);
    rd(5'h08, v); chk("R7 err cleared", v, 32'h0);

    // R9 autoexec on data0
    wr(5'h0A, 32'h1);
    wr(5'h00, 32'h0000_D00D);
    chk("R9 write relaunch busy", {31'b0, busy}, 32'h1);
    chk("R9 write relaunch valid", {31'b0, hartCmdValid}, 32'h1);
    chk("R9 last cmd", hartCmd, 32'h00C0_FFEE);
    chk("R9 new operand", hartArgs[31:0], 32'h0000_D00D);
    // R6 autoexec access while busy
    rd(5'h00, v);
    rd(5'h08, v); chk("R6 autoexec busy err", v, 32'h101);
    done(32'h0000_0042);
    wr(5'h08, 32'h7);
    rd(5'h01, v);
    chk("R9 unmarked read no launch", {31'b0, busy}, 32'h0);
    rd(5'h00, v);
    chk("R9 read value", v, 32'h0000_0042);
    chk("R9 read relaunch", {31'b0, busy}, 32'h1);
    done(32'h0000_0077);
    wr(5'h0A, 32'h0);

    // R5 done while idle ignored
    done(32'hFFFF_0000);
    chk("R5 idle done ignored", hartArgs[31:0], 32'h0000_0077);
    chk("R5 idle busy", {31'b0, busy}, 32'h0);

    // R8 buffer write never launches, no inserted word
    wr(5'h17, 32'h0000_0013);
    chk("R8 pb write no launch", {31'b0, busy}, 32'h0);
    rd(5'h17, v); chk("R8 exact readback", v, 32'h0000_0013);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule